// File: doc/BRIEF.md
# Leveled Interrupt Acceptance Controller

This block sits between a group of peripheral interrupt sources and the processor core. Each source has three things. The first is a cause flip-flop, which a peripheral event pulse sets and a clear strobe resets. The second is an enable bit. The third is a 3-bit priority level together with a routing bit. In every cycle the block finds the best pending source: the lowest level wins, and on a tie the lowest index wins. The request is accepted only when that level is strictly below the processor's current level mask and the global interrupt-enable flag is set.

An accepted request whose routing bit is 0 becomes a CPU interrupt. The block pulses an acknowledge with the source index and level, loads the level mask with that level and clears the enable flag. An accepted request whose routing bit is 1 instead pulses a start strobe to the automatic transfer service and leaves the processor status alone. A software trap always produces an interrupt. It clears the enable flag and keeps the mask. A return input restores the mask and the enable flag saved when the last interrupt or trap was taken. A status-write port lets the core load the mask and enable flag directly.

Top module: `irq_accept_ctrl`

## Requirements
- R1: A source's cause flip-flop is set by a one-cycle `evt_i` pulse and cleared by `clr_i`. When both arrive in the same cycle, the set wins.
- R2: A source takes part in arbitration only while its cause flip-flop is set and its `en_i` bit is 1.
- R3: A request is accepted only if its level is strictly below `ilm_o`. Level 7 is never accepted.
- R4: No request is accepted while `ie_o` is 0.
- R5: Among the eligible sources, the one with the numerically lowest level wins. On equal levels, the lowest index wins.
- R6: On acceptance with routing bit 0, `ack_o` is high for exactly one cycle, one clock after the deciding edge's inputs. In that same cycle `ack_id_o` and `ack_lvl_o` give the winner, `ilm_o` equals the winner's level and `ie_o` is 0.
- R7: On acceptance with routing bit 1, `svc_start_o` pulses with `svc_id_o` and `ilm_o` and `ie_o` are unchanged. That source cannot start the service again until its cause is cleared, and other sources may still be accepted meanwhile.
- R8: `swi_i` produces a one-cycle `trap_o`, clears `ie_o` and keeps `ilm_o`. A hardware acceptance in the same cycle is suppressed.
- R9: `reti_i` restores `ilm_o` and `ie_o` to the values held just before the last interrupt or trap was taken. No acceptance happens in a cycle with `reti_i`.
- R10: Synchronous reset gives `ilm_o` = 7, `ie_o` = 1, and all pulse outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NSRC | Peripheral event pulses, one per source |
| clr_i | input | NSRC | Cause clear strobes, one per source |
| en_i | input | NSRC | Per-source enable bits |
| lvl_i | input | NSRC*3 | Per-source levels; source i at bits [3i+2:3i] |
| svc_i | input | NSRC | Per-source routing bit: 1 = transfer service, 0 = CPU interrupt |
| swi_i | input | 1 | Software trap request |
| reti_i | input | 1 | Return from interrupt |
| ps_wr_i | input | 1 | Load mask and enable flag from the core |
| ps_ilm_i | input | 3 | Mask value for the status write |
| ps_ie_i | input | 1 | Enable flag value for the status write |
| ack_o | output | 1 | CPU interrupt acknowledge pulse |
| ack_id_o | output | $clog2(NSRC) | Index of the acknowledged source |
| ack_lvl_o | output | 3 | Level of the acknowledged source |
| svc_start_o | output | 1 | Transfer service start pulse |
| svc_id_o | output | $clog2(NSRC) | Index of the source handed to the service |
| trap_o | output | 1 | Software trap taken pulse |
| ilm_o | output | 3 | Current level mask |
| ie_o | output | 1 | Current global interrupt-enable flag |

## Verification
The assertions take for granted that `reti_i`, `swi_i` and `ps_wr_i` are never high together. They also take for granted that event and clear strobes last a single cycle and that the level and routing inputs stay still while a request is being decided. The stimulus raises at most one of the three status-changing inputs per cycle. It changes levels, enables and routing only while the affected causes are clear or the enable flag is low. It pulses every strobe for exactly one clock, so that each acceptance comes from a known edge.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  // highest encoding marks a source as switched off
  localparam lvl_t LVL_OFF = '1;
endpackage

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] take_i,
  output logic [NSRC-1:0] cause_o,
  output logic [NSRC-1:0] busy_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        cause_o[g] <= 1'b0;
      end else if (evt_i[g]) begin
        cause_o[g] <= 1'b1;
      end else if (clr_i[g]) begin
        cause_o[g] <= 1'b0;
      end
    end

    // busy marks a source already handed to the transfer service
    always_ff @(posedge clk) begin
      if (rst) begin
        busy_o[g] <= 1'b0;
      end else if (take_i[g]) begin
        busy_o[g] <= 1'b1;
      end else if (clr_i[g]) begin
        busy_o[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_accept_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] req_i,
  input  lvl_t [NSRC-1:0] lvl_i,
  output logic            hit_o,
  output logic [IDW-1:0]  id_o,
  output lvl_t            lvl_o
);
  always_comb begin
    hit_o = 1'b0;
    id_o  = '0;
    lvl_o = LVL_OFF;
    // strict compare keeps the earlier index on ties and never picks LVL_OFF
    for (int i = 0; i < NSRC; i++) begin
      if (req_i[i] && (lvl_i[i] < lvl_o)) begin
        hit_o = 1'b1;
        id_o  = IDW'(i);
        lvl_o = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_status.sv
module irq_status
  import irq_accept_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hit_i,
  input  logic [IDW-1:0] win_id_i,
  input  lvl_t           win_lvl_i,
  input  logic           win_svc_i,
  input  logic           swi_i,
  input  logic           reti_i,
  input  logic           ps_wr_i,
  input  lvl_t           ps_ilm_i,
  input  logic           ps_ie_i,
  output logic           take_svc_o,
  output logic           ack_o,
  output logic [IDW-1:0] ack_id_o,
  output lvl_t           ack_lvl_o,
  output logic           svc_start_o,
  output logic [IDW-1:0] svc_id_o,
  output logic           trap_o,
  output lvl_t           ilm_o,
  output logic           ie_o
);
  lvl_t ilm_q, sv_ilm_q;
  logic ie_q, sv_ie_q;
  logic pass, take_irq;

  assign pass       = hit_i && (win_lvl_i < ilm_q) && ie_q && !reti_i && !swi_i && !ps_wr_i;
  assign take_irq   = pass && !win_svc_i;
  assign take_svc_o = pass && win_svc_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ilm_q       <= LVL_OFF;
      ie_q        <= 1'b1;
      sv_ilm_q    <= LVL_OFF;
      sv_ie_q     <= 1'b1;
      ack_o       <= 1'b0;
      ack_id_o    <= '0;
      ack_lvl_o   <= '0;
      svc_start_o <= 1'b0;
      svc_id_o    <= '0;
      trap_o      <= 1'b0;
    end else begin
      ack_o       <= 1'b0;
      svc_start_o <= 1'b0;
      trap_o      <= 1'b0;
      if (reti_i) begin
        ilm_q <= sv_ilm_q;
        ie_q  <= sv_ie_q;
      end else if (swi_i) begin
        sv_ilm_q <= ilm_q;
        sv_ie_q  <= ie_q;
        ie_q     <= 1'b0;
        trap_o   <= 1'b1;
      end else if (ps_wr_i) begin
        ilm_q <= ps_ilm_i;
        ie_q  <= ps_ie_i;
      end else if (take_irq) begin
        sv_ilm_q  <= ilm_q;
        sv_ie_q   <= ie_q;
        ilm_q     <= win_lvl_i;
        ie_q      <= 1'b0;
        ack_o     <= 1'b1;
        ack_id_o  <= win_id_i;
        ack_lvl_o <= win_lvl_i;
      end else if (take_svc_o) begin
        svc_start_o <= 1'b1;
        svc_id_o    <= win_id_i;
      end
    end
  end

  assign ilm_o = ilm_q;
  assign ie_o  = ie_q;
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_accept_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSRC-1:0]       evt_i,
  input  logic [NSRC-1:0]       clr_i,
  input  logic [NSRC-1:0]       en_i,
  input  logic [NSRC*LVL_W-1:0] lvl_i,
  input  logic [NSRC-1:0]       svc_i,
  input  logic                  swi_i,
  input  logic                  reti_i,
  input  logic                  ps_wr_i,
  input  logic [LVL_W-1:0]      ps_ilm_i,
  input  logic                  ps_ie_i,
  output logic                  ack_o,
  output logic [IDW-1:0]        ack_id_o,
  output logic [LVL_W-1:0]      ack_lvl_o,
  output logic                  svc_start_o,
  output logic [IDW-1:0]        svc_id_o,
  output logic                  trap_o,
  output logic [LVL_W-1:0]      ilm_o,
  output logic                  ie_o
);
  lvl_t [NSRC-1:0] lvl_arr;
  logic [NSRC-1:0] cause, busy, req, take_vec;
  logic            hit, take_svc;
  logic [IDW-1:0]  win_id;
  lvl_t            win_lvl;

  for (genvar g = 0; g < NSRC; g++) begin : g_lvl
    assign lvl_arr[g] = lvl_i[g*LVL_W +: LVL_W];
  end

  assign req      = cause & en_i & ~busy;
  assign take_vec = take_svc ? (NSRC'(1) << win_id) : '0;

  irq_cause_bank #(.NSRC(NSRC)) u_bank (
    .clk(clk), .rst(rst), .evt_i(evt_i), .clr_i(clr_i), .take_i(take_vec),
    .cause_o(cause), .busy_o(busy)
  );

  irq_prio_arb #(.NSRC(NSRC)) u_arb (
    .req_i(req), .lvl_i(lvl_arr), .hit_o(hit), .id_o(win_id), .lvl_o(win_lvl)
  );

  irq_status #(.NSRC(NSRC)) u_stat (
    .clk(clk), .rst(rst), .hit_i(hit), .win_id_i(win_id), .win_lvl_i(win_lvl),
    .win_svc_i(svc_i[win_id]), .swi_i(swi_i), .reti_i(reti_i),
    .ps_wr_i(ps_wr_i), .ps_ilm_i(ps_ilm_i), .ps_ie_i(ps_ie_i),
    .take_svc_o(take_svc), .ack_o(ack_o), .ack_id_o(ack_id_o),
    .ack_lvl_o(ack_lvl_o), .svc_start_o(svc_start_o), .svc_id_o(svc_id_o),
    .trap_o(trap_o), .ilm_o(ilm_o), .ie_o(ie_o)
  );
endmodule

// File: rtl/irq_accept_ctrl_chk.sv
module irq_accept_ctrl_chk #(
  parameter int NSRC = 8,
  parameter int LVL_W = 3,
  localparam int IDW = $clog2(NSRC)
) (
  input logic             clk,
  input logic             rst,
  input logic             ack_o,
  input logic [LVL_W-1:0] ack_lvl_o,
  input logic             svc_start_o,
  input logic [IDW-1:0]   svc_id_o,
  input logic             trap_o,
  input logic [LVL_W-1:0] ilm_o,
  input logic             ie_o,
  input logic             reti_i
);
  // R6
  ack_status_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> (!ie_o && ilm_o == ack_lvl_o));
  // R6
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);
  // R3
  ack_below_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> (ack_lvl_o < $past(ilm_o)));
  // R4
  accept_needs_ie_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_o || svc_start_o) |-> $past(ie_o));
  // R7
  svc_keeps_status_chk: assert property (@(posedge clk) disable iff (rst)
    svc_start_o |-> (ilm_o == $past(ilm_o) && ie_o == $past(ie_o)));
  // R7
  svc_no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    svc_start_o |=> (!svc_start_o || svc_id_o != $past(svc_id_o)));
  // R8
  trap_status_chk: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (!ie_o && ilm_o == $past(ilm_o)));
  // R9
  reti_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    $past(reti_i) |-> (!ack_o && !svc_start_o && !trap_o));
  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ack_o, svc_start_o, trap_o}));
endmodule

bind irq_accept_ctrl irq_accept_ctrl_chk #(.NSRC(NSRC), .LVL_W(irq_accept_pkg::LVL_W)) u_chk (
  .clk(clk), .rst(rst), .ack_o(ack_o), .ack_lvl_o(ack_lvl_o),
  .svc_start_o(svc_start_o), .svc_id_o(svc_id_o), .trap_o(trap_o),
  .ilm_o(ilm_o), .ie_o(ie_o), .reti_i(reti_i)
);

// File: tb/irq_accept_ctrl_bench.sv
module irq_accept_ctrl_bench;
  localparam int N = 4;
  localparam int IDW = $clog2(N);

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] evt, clr, en, svc;
  logic [2:0] lvl [N];
  logic [N*3-1:0] lvl_bus;
  logic swi, reti, ps_wr, ps_ie;
  logic [2:0] ps_ilm;
  logic ack, svc_start, trap, ie;
  logic [IDW-1:0] ack_id, svc_id;
  logic [2:0] ack_lvl, ilm;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) lvl_bus[i*3 +: 3] = lvl[i];
  end

  irq_accept_ctrl #(.NSRC(N)) u_irq_accept_ctrl (
    .clk(clk), .rst(rst), .evt_i(evt), .clr_i(clr), .en_i(en), .lvl_i(lvl_bus),
    .svc_i(svc), .swi_i(swi), .reti_i(reti), .ps_wr_i(ps_wr), .ps_ilm_i(ps_ilm),
    .ps_ie_i(ps_ie), .ack_o(ack), .ack_id_o(ack_id), .ack_lvl_o(ack_lvl),
    .svc_start_o(svc_start), .svc_id_o(svc_id), .trap_o(trap), .ilm_o(ilm), .ie_o(ie)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic ps_write(input int m, input logic e);
    ps_wr = 1'b1; ps_ilm = 3'(m); ps_ie = e;
    tick();
    ps_wr = 1'b0;
  endtask

  task automatic clear_all();
    en = '0; svc = '0; clr = '1;
    tick();
    clr = '0;
    ps_write(7, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; evt = '0; clr = '0; en = '0; svc = '0;
    swi = 0; reti = 0; ps_wr = 0; ps_ie = 0; ps_ilm = '0;
    for (int i = 0; i < N; i++) lvl[i] = '1;
    repeat (4) tick();
    rst = 1'b0;
    tick();
    // R10 reset state
    chk("R10 ilm", int'(ilm), 7);
    chk("R10 ie", int'(ie), 1);
    chk("R10 pulses", int'({ack, svc_start, trap}), 0);

    // R3 R6: sweep every mask against every level on source 0
    for (int m = 0; m < 8; m++) begin
      for (int l = 0; l < 8; l++) begin
        clear_all();
        ps_write(m, 1'b1);
        lvl[0] = 3'(l); en[0] = 1'b1; evt[0] = 1'b1;
        tick();
        evt[0] = 1'b0;
        tick();
        chk("R3 accept", int'(ack), int'(l < m));
        if (l < m) begin
          chk("R6 id", int'(ack_id), 0);
          chk("R6 lvl", int'(ack_lvl), l);
          chk("R6 ilm", int'(ilm), l);
          chk("R6 ie", int'(ie), 0);
          tick();
          chk("R6 one pulse", int'(ack), 0);
        end else begin
          chk("R3 ilm kept", int'(ilm), m);
        end
      end
    end

    // R2 R5: all enable patterns and level mixes of 2 and 3
    for (int p = 0; p < 256; p++) begin
      int best_l, best_i;
      clear_all();
      for (int i = 0; i < N; i++) lvl[i] = 3'(2 + ((p >> (4 + i)) & 1));
      evt = '1;
      tick();
      evt = '0; en = 4'(p);
      tick();
      best_l = 8; best_i = 0;
      for (int i = 0; i < N; i++)
        if (en[i] && int'(lvl[i]) < best_l) begin best_l = int'(lvl[i]); best_i = i; end
      chk("R2 any", int'(ack), int'(best_l < 8));
      if (best_l < 8) begin
        chk("R5 winner", int'(ack_id), best_i);
        chk("R5 level", int'(ack_lvl), best_l);
      end
    end

    // R1: clear alone empties the cause; set and clear together keep it
    clear_all();
    lvl[0] = 3'd2; en[0] = 1'b1;
    ps_write(7, 1'b0);
    evt[0] = 1'b1; tick(); evt[0] = 1'b0;
    clr[0] = 1'b1; tick(); clr[0] = 1'b0;
    ps_write(7, 1'b1);
    tick();
    chk("R1 cleared", int'(ack), 0);
    ps_write(7, 1'b0);
    evt[0] = 1'b1; clr[0] = 1'b1; tick(); evt[0] = 1'b0; clr[0] = 1'b0;
    ps_write(7, 1'b1);
    tick();
    chk("R1 set wins", int'(ack), 1);

    // R4: enable flag low blocks everything
    clear_all();
    ps_write(7, 1'b0);
    lvl[1] = 3'd0; en[1] = 1'b1; evt[1] = 1'b1; tick(); evt[1] = 1'b0;
    tick(); tick();
    chk("R4 blocked", int'({ack, svc_start}), 0);

    // R7: service routing, busy hold-off, other source still served
    clear_all();
    lvl[1] = 3'd2; svc[1] = 1'b1; en[1] = 1'b1;
    lvl[2] = 3'd4; en[2] = 1'b1;
    evt[1] = 1'b1; evt[2] = 1'b1; tick(); evt = '0;
    tick();
    chk("R7 start", int'(svc_start), 1);
    chk("R7 id", int'(svc_id), 1);
    chk("R7 no ack", int'(ack), 0);
    chk("R7 ilm", int'(ilm), 7);
    chk("R7 ie", int'(ie), 1);
    tick();
    chk("R7 other acked", int'(ack), 1);
    chk("R7 other id", int'(ack_id), 2);
    chk("R7 no restart", int'(svc_start), 0);
    clr[2] = 1'b1; reti = 1'b1; tick(); clr[2] = 1'b0; reti = 1'b0;
    chk("R9 ilm back", int'(ilm), 7);
    chk("R9 ie back", int'(ie), 1);
    chk("R9 no accept", int'({ack, svc_start}), 0);
    tick();
    chk("R7 busy holds", int'(svc_start), 0);
    clr[1] = 1'b1; tick(); clr[1] = 1'b0;
    evt[1] = 1'b1; tick(); evt[1] = 1'b0;
    tick();
    chk("R7 restart", int'(svc_start), 1);

    // R8 R9: trap beats a pending request, return reopens it
    clear_all();
    ps_write(5, 1'b1);
    lvl[0] = 3'd1; en[0] = 1'b1;
    evt[0] = 1'b1; tick(); evt[0] = 1'b0;
    swi = 1'b1; tick(); swi = 1'b0;
    chk("R8 trap", int'(trap), 1);
    chk("R8 no ack", int'(ack), 0);
    chk("R8 ilm kept", int'(ilm), 5);
    chk("R8 ie cleared", int'(ie), 0);
    tick();
    chk("R8 one pulse", int'({trap, ack}), 0);
    reti = 1'b1; tick(); reti = 1'b0;
    chk("R9 ilm", int'(ilm), 5);
    chk("R9 ie", int'(ie), 1);
    tick();
    chk("R9 pending taken", int'(ack), 1);
    chk("R9 new ilm", int'(ilm), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule